// File: doc/BRIEF.md
# Fractional clock divider with clean enable and phase control

The block turns one input clock into a slower generated clock. The divisor has an integer part and an 8-bit fractional part. A first-order accumulator spreads the fraction over successive output periods: some periods are one input cycle longer than the integer part. Control is by plain level inputs: a clean enable, an immediate kill, optional 50% duty correction for odd period lengths, a 0 to 3 cycle delay on the enable, and a nudge input that moves the output phase back by one input cycle on each rising edge.

The whole model sits in the input clock domain, so it can be simulated. The generated clock is given as two bits per input cycle. `clk_o[1]` is the level during the first half of the input cycle and `clk_o[0]` is the level during the second half. With this form an odd period can be shaped to an exact 50% duty cycle. A divisor change takes effect at the next period boundary. The block needs no reset for this. The recommended idle divisor is integer 1, fraction 0.

Top module: `frac_clk_gen`

## Requirements
- R1: During and after reset, `clk_o` is 2'b00, `enabled_o` is 0 and the fraction accumulator is zero.
- R2: Each period lasts N + c input cycles. N is the integer part and c is the carry out of adding the 8-bit fraction to an 8-bit accumulator once per period. The accumulator starts at zero.
- R3: An integer part of 0 gives N = 65536.
- R4: Without duty correction, a period of P cycles has `clk_o` = 2'b11 for its first ceil(P/2) cycles and 2'b00 for the rest. Bit 1 of `clk_o` is the first half of the input cycle and bit 0 is the second half.
- R5: With duty correction and P odd, the period has ceil(P/2)-1 cycles of 2'b11, then one cycle of 2'b10, then 2'b00 to its end. An even P has the same shape as in R4.
- R6: When the effective enable rises, `enabled_o` rises at the next clock edge. The first output cycle is the start of a full period, so no shortened pulse appears.
- R7: When the effective enable falls, the current period runs to its end. `enabled_o` then falls at that period boundary and the output stays 2'b00.
- R8: `kill_i` forces `clk_o` to 2'b00 in the same cycle. `enabled_o` drops at the next edge and the accumulator is cleared. When kill is released with the enable still high, a full period starts.
- R9: `phase_i` delays the enable by 0 to 3 input cycles, for both start and stop.
- R10: A rising edge on `nudge_i`, compared with its value in the previous cycle, holds the period position for one input cycle. This lengthens the running period by one cycle. Holding the input high has no further effect.
- R11: The divisor and the duty-correction setting are captured at the start of each period. A change in mid-period shapes only the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Clean start/stop request |
| kill_i | input | 1 | Immediate stop |
| dc50_i | input | 1 | Duty correction for odd period lengths |
| phase_i | input | 2 | Enable delay in input cycles |
| nudge_i | input | 1 | Each rising edge slips phase by one cycle |
| div_int_i | input | 24 | Integer divisor, 0 means 65536 |
| div_frac_i | input | 8 | Fractional divisor in 1/256 steps |
| clk_o | output | 2 | Generated clock, {first half, second half} of each input cycle |
| enabled_o | output | 1 | Generator running |

## Verification
Integer divisors of 4 and 5 with duty correction on and off separate the even shape from the two odd shapes. A divisor of 3 plus one half yields alternating periods of 3 and 4 cycles, which shows that the carry lands on the right period. Divisor changes in mid-period, phase settings, nudge pulses and kills in the middle of a period each test one control path against a cycle-level reference model. A long run with random control changes tests the paths together. A final run at integer 0 checks the 65536 case over one whole period.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;
endpackage

// File: rtl/fcg_period.sv
module fcg_period #(
  parameter int INT_W     = 24,
  parameter int FRAC_W    = 8,
  parameter int ZERO_LOG2 = 16,
  localparam int LEN_W    = INT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kill_i,
  input  logic              load_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic              dc50_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [LEN_W-1:0]  hi_o,
  output logic              half_o
);
  localparam logic [LEN_W-1:0] ZERO_DIV = LEN_W'(1) << ZERO_LOG2;

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic [LEN_W-1:0]  base, len_d, ceil_d, hi_d;
  logic              half_d;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, div_frac_i};
    base   = (div_int_i == '0) ? ZERO_DIV : {1'b0, div_int_i};
    len_d  = base + LEN_W'(sum[FRAC_W]);
    ceil_d = (len_d + LEN_W'(1)) >> 1;
    half_d = dc50_i & len_d[0];
    // with correction the last high cycle is a half cycle
    hi_d   = half_d ? ceil_d - LEN_W'(1) : ceil_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      len_o  <= LEN_W'(1);
      hi_o   <= LEN_W'(1);
      half_o <= 1'b0;
    end else if (kill_i) begin
      acc_q  <= '0;
    end else if (load_i) begin
      acc_q  <= sum[FRAC_W-1:0];
      len_o  <= len_d;
      hi_o   <= hi_d;
      half_o <= half_d;
    end
  end

  assert_frac_zero_keeps_acc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !kill_i && div_frac_i == '0) |=> acc_q == $past(acc_q));

  assert_len_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_o != '0);
endmodule

// File: rtl/fcg_ctrl.sv
module fcg_ctrl #(
  parameter int PH_W   = 2,
  localparam int DEPTH = (1 << PH_W) - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            nudge_i,
  input  logic            kill_i,
  input  logic            period_end_i,
  output logic            run_o,
  output logic            load_o,
  output logic            stall_o
);
  import fcg_pkg::*;

  run_state_e       state_q;
  logic [DEPTH-1:0] dly_q;
  logic [DEPTH:0]   taps;
  logic             en_eff, nudge_q;

  generate
    if (DEPTH == 1) begin : g_dly1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= enable_i;
    end else begin : g_dlyn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= {dly_q[DEPTH-2:0], enable_i};
    end
  endgenerate

  assign taps    = {dly_q, enable_i};
  assign en_eff  = taps[phase_i];
  assign stall_o = nudge_i & ~nudge_q;
  assign run_o   = (state_q == ST_RUN);
  assign load_o  = ~kill_i & en_eff & (~run_o | period_end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nudge_q <= 1'b0;
    end else begin
      nudge_q <= nudge_i;
      if (kill_i)                                 state_q <= ST_IDLE;
      else if (!run_o && en_eff)                  state_q <= ST_RUN;
      else if (run_o && period_end_i && !en_eff)  state_q <= ST_IDLE;
    end
  end

  assert_kill_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !run_o);

  assert_clean_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> ($past(kill_i) || $past(period_end_i)));
endmodule

// File: rtl/fcg_wave.sv
module fcg_wave #(
  parameter int LEN_W = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stall_i,
  input  logic             kill_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] hi_i,
  input  logic             half_i,
  output logic             period_end_o,
  output logic [1:0]       clk_o
);
  logic [LEN_W-1:0] pos_q;
  logic             full_hi, half_hi;

  assign period_end_o = run_i & ~stall_i & (pos_q == len_i - LEN_W'(1));
  assign full_hi      = (pos_q < hi_i);
  assign half_hi      = half_i & (pos_q == hi_i);
  assign clk_o        = (run_i && !kill_i) ? {full_hi | half_hi, full_hi} : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       pos_q <= '0;
    else if (kill_i || period_end_o)   pos_q <= '0;
    else if (run_i && !stall_i)        pos_q <= pos_q + LEN_W'(1);
  end

  assert_pos_in_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> pos_q < len_i);

  assert_nudge_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && stall_i && !kill_i) |=> pos_q == $past(pos_q));
endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen #(
  parameter int INT_W     = 24,
  parameter int FRAC_W    = 8,
  parameter int PH_W      = 2,
  parameter int ZERO_LOG2 = 16,
  localparam int LEN_W    = INT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              kill_i,
  input  logic              dc50_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic              nudge_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic [1:0]        clk_o,
  output logic              enabled_o
);
  logic             run, load, stall, period_end, half;
  logic [LEN_W-1:0] len, hi;

  fcg_ctrl #(.PH_W(PH_W)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .phase_i, .nudge_i, .kill_i,
    .period_end_i(period_end), .run_o(run), .load_o(load), .stall_o(stall)
  );

  fcg_period #(.INT_W(INT_W), .FRAC_W(FRAC_W), .ZERO_LOG2(ZERO_LOG2)) u_period (
    .clk_i, .rst_ni, .kill_i, .load_i(load), .div_int_i, .div_frac_i, .dc50_i,
    .len_o(len), .hi_o(hi), .half_o(half)
  );

  fcg_wave #(.LEN_W(LEN_W)) u_wave (
    .clk_i, .rst_ni, .run_i(run), .stall_i(stall), .kill_i,
    .len_i(len), .hi_i(hi), .half_i(half),
    .period_end_o(period_end), .clk_o
  );

  assign enabled_o = run;

  assert_kill_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> clk_o == 2'b00);
endmodule

// File: tb/sim_frac_clk_gen.sv
`timescale 1ns/1ps
module sim_frac_clk_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0, kill_i = 1'b0, dc50_i = 1'b0, nudge_i = 1'b0;
  logic [1:0]  phase_i = 2'd0;
  logic [23:0] div_int_i = 24'd1;
  logic [7:0]  div_frac_i = 8'd0;
  logic [1:0]  clk_o;
  logic        enabled_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frac_clk_gen u0 (
    .clk_i(clk), .rst_ni, .enable_i, .kill_i, .dc50_i, .phase_i, .nudge_i,
    .div_int_i, .div_frac_i, .clk_o, .enabled_o
  );

  // reference model state
  int m_run, m_pos, m_len, m_acc, m_dc, m_nprev;
  int m_dly [3];

  function automatic int wave(int len, int pos, int dc);
    int h = (len + 1) / 2;
    if (dc != 0 && (len % 2) == 1) begin
      if (pos < h - 1) return 3;
      if (pos == h - 1) return 2;
      return 0;
    end
    return (pos < h) ? 3 : 0;
  endfunction

  task automatic m_load();
    int s = m_acc + int'(div_frac_i);
    int n = (div_int_i == 0) ? 65536 : int'(div_int_i);
    m_len = n + s / 256;
    m_acc = s % 256;
    m_dc  = int'(dc50_i);
    m_pos = 0;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_pos = 0; m_len = 1; m_acc = 0; m_dc = 0; m_nprev = 0;
      for (int i = 0; i < 3; i++) m_dly[i] = 0;
    end else begin
      int en, st;
      en = (phase_i == 0) ? int'(enable_i) : m_dly[phase_i - 1];
      st = (nudge_i && m_nprev == 0) ? 1 : 0;
      if (kill_i) begin
        m_run = 0; m_pos = 0; m_acc = 0;
      end else if (m_run == 0) begin
        if (en != 0) begin m_run = 1; m_load(); end
      end else if (st == 0) begin
        if (m_pos == m_len - 1) begin
          if (en != 0) m_load();
          else begin m_run = 0; m_pos = 0; end
        end else m_pos++;
      end
      m_dly[2] = m_dly[1]; m_dly[1] = m_dly[0]; m_dly[0] = int'(enable_i);
      m_nprev = int'(nudge_i);
    end
  end

  task automatic check(string tag);
    logic [1:0] ec;
    logic       ee;
    ec = (m_run != 0 && !kill_i) ? 2'(wave(m_len, m_pos, m_dc)) : 2'b00;
    ee = (m_run != 0);
    checks++;
    if (clk_o !== ec || enabled_o !== ee) begin
      errors++;
      $display("FAIL %s: clk_o=%b exp %b, enabled_o=%b exp %b", tag, clk_o, ec, enabled_o, ee);
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d exp below 190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R1 reset state
    run(3, "R1");
    rst_ni = 1'b1;
    run(2, "R1");
    // R4 even divide, R6 start
    div_int_i = 24'd4; enable_i = 1'b1;
    run(3, "R6");
    run(17, "R4");
    // R5 odd with and without duty correction
    div_int_i = 24'd5; dc50_i = 1'b1;
    run(30, "R5");
    dc50_i = 1'b0;
    run(20, "R4");
    // R2 fractional carry pattern 3,4,3,4
    dc50_i = 1'b1; div_int_i = 24'd3; div_frac_i = 8'h80;
    run(40, "R2");
    // R11 change mid period
    run(2, "R11");
    div_int_i = 24'd7; div_frac_i = 8'h00;
    run(20, "R11");
    // R7 clean stop
    enable_i = 1'b0;
    run(20, "R7");
    // R9 phase delay on start and stop
    phase_i = 2'd3; div_int_i = 24'd2; enable_i = 1'b1;
    run(12, "R9");
    phase_i = 2'd2; enable_i = 1'b0;
    run(12, "R9");
    phase_i = 2'd0; enable_i = 1'b1; div_int_i = 24'd6;
    // R10 nudge edges and held level
    run(5, "R10");
    nudge_i = 1'b1; run(6, "R10");
    nudge_i = 1'b0; run(1, "R10");
    nudge_i = 1'b1; run(1, "R10");
    nudge_i = 1'b0; run(12, "R10");
    // R8 kill mid period, release with enable high
    div_frac_i = 8'h40; run(3, "R8");
    kill_i = 1'b1; run(3, "R8");
    kill_i = 1'b0; run(20, "R8");
    // mixed random traffic (R2/R11)
    for (int i = 0; i < 15000; i++) begin
      if ($urandom_range(39) == 0) enable_i = ~enable_i;
      kill_i = ($urandom_range(199) == 0);
      if ($urandom_range(7) == 0) nudge_i = ~nudge_i;
      if ($urandom_range(99) == 0) phase_i = 2'($urandom_range(3));
      if ($urandom_range(29) == 0) div_int_i = 24'($urandom_range(9, 1));
      if ($urandom_range(29) == 0) div_frac_i = 8'($urandom_range(255));
      if ($urandom_range(49) == 0) dc50_i = ~dc50_i;
      run(1, "R2/R11");
    end
    // R3 integer zero
    kill_i = 1'b0; nudge_i = 1'b0; phase_i = 2'd0; enable_i = 1'b0;
    div_int_i = 24'd1; div_frac_i = 8'd0;
    run(20, "R3");
    kill_i = 1'b1; run(1, "R3");
    kill_i = 1'b0; div_int_i = 24'd0; dc50_i = 1'b0; enable_i = 1'b1;
    run(65600, "R3");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule